// File: doc/BRIEF.md
# Mixed-Width Shared Dual-Port Memory

This block is one storage array reached through two fully independent ports. Each port has its own clock, reset, enable, write enable, address, write data and read data. Both ports see the same bits, but at different data widths. By default the narrow port addresses 1024 words of 13 bits. The wide port addresses 512 words of 26 bits. Every wide word is two narrow words placed side by side with no padding between them.

Packing is little-endian. The even narrow address of a pair holds the low slice of the wide word, and the odd address holds the high slice. Either port can read and write. Read data is registered on the port's own clock. The width ratio is a build-time parameter. The wide port writes whole words only. A typical use is rate or width conversion between two clock domains, where one side moves narrow samples and the other side moves them in pairs.

Top module: `asym_dpram`

## Requirements
- R1: Geometry. The narrow port has WIDE_DEPTH*RATIO words of NARROW_W bits (default 1024 x 13). The wide port has WIDE_DEPTH words of NARROW_W*RATIO bits (default 512 x 26). Both ports address the same storage.
- R2: Mapping. Narrow address 2k holds bits [12:0] of wide word k, and narrow address 2k+1 holds bits [25:13]. In general, narrow address a is slice (a mod RATIO) of wide word a/RATIO. Slices are contiguous.
- R3: A narrow write changes only its own 13-bit slice. The other slice of the same wide word keeps its value.
- R4: A wide write replaces all 26 bits of the addressed word. There is no partial write enable.
- R5: Reads are synchronous. When a port's enable is high at a rising edge of that port's clock, its read data shows the addressed contents after that edge. The port's other signals need no further cycle.
- R6: Each port is read-first. An enabled write returns, on that port, the contents from before the write.
- R7: While a port's enable is low, its write enable, address and data are ignored. The storage is unchanged and the port's read data holds its value.
- R8: Each port has an asynchronous active-low reset. The reset clears that port's read data to zero at once, and release is synchronised to the port's clock. Reset does not alter the storage or the other port.
- R9: The two ports run on unrelated clocks. Data written through one port can be read back through the other, as long as the two ports never write overlapping bits in the same instant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| n_clk | input | 1 | Narrow port clock |
| n_rst_n | input | 1 | Narrow port asynchronous reset, active low |
| n_en | input | 1 | Narrow port enable |
| n_we | input | 1 | Narrow port write enable, used when n_en is high |
| n_addr | input | 10 | Narrow word address |
| n_wdata | input | 13 | Narrow write data |
| n_rdata | output | 13 | Narrow registered read data |
| w_clk | input | 1 | Wide port clock |
| w_rst_n | input | 1 | Wide port asynchronous reset, active low |
| w_en | input | 1 | Wide port enable |
| w_we | input | 1 | Wide port write enable, used when w_en is high |
| w_addr | input | 9 | Wide word address |
| w_wdata | input | 26 | Wide write data |
| w_rdata | output | 26 | Wide registered read data |

## Verification
The case hardest to reach from the ports is both clocks active at once. In that case one port's writes must become visible to the other port's reads while both domains are busy. The stimulus forks two threads on clocks of 8 ns and 11 ns. The narrow thread rewrites a low band of rows while the wide thread reads a disjoint band, and a wide read sweep afterwards checks the merged result. Exhaustive sweeps also cover the slice behaviour: every word is written on one side and read on the other. Odd-only narrow rewrites then show that the neighbouring even slices stay intact.

// File: rtl/asym_dpram_pkg.sv
package asym_dpram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } port_op_e;

  function automatic port_op_e port_op(input logic en, input logic we);
    if (!en)     return OP_IDLE;
    else if (we) return OP_WRITE;
    else         return OP_READ;
  endfunction

endpackage

// File: rtl/asym_rst_sync.sv
module asym_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_n_out = stage1_q;
endmodule

// File: rtl/asym_lane_store.sv
// One slice lane of the shared array. Each clock domain owns one bank, and
// the stored value is the XOR of both banks, so no bank has two writers.
module asym_lane_store #(
  parameter int W     = 13,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          a_clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_row,
  input  logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_word,
  input  logic          b_clk,
  input  logic          b_we,
  input  logic [AW-1:0] b_row,
  input  logic [W-1:0]  b_wdata,
  output logic [W-1:0]  b_word
);
  logic [W-1:0] bank_a [DEPTH];
  logic [W-1:0] bank_b [DEPTH];

  always_ff @(posedge a_clk) begin
    if (a_we) begin
      bank_a[a_row] <= a_wdata ^ bank_b[a_row];
    end
  end

  always_ff @(posedge b_clk) begin
    if (b_we) begin
      bank_b[b_row] <= b_wdata ^ bank_a[b_row];
    end
  end

  assign a_word = bank_a[a_row] ^ bank_b[a_row];
  assign b_word = bank_a[b_row] ^ bank_b[b_row];
endmodule

// File: rtl/asym_read_reg.sv
module asym_read_reg #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q)); // R7

  AST_RD_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (q == '0)); // R8
endmodule

// File: rtl/asym_dpram.sv
module asym_dpram #(
  parameter int NARROW_W   = 13,
  parameter int RATIO      = 2,
  parameter int WIDE_DEPTH = 512,
  localparam int NARROW_DEPTH = WIDE_DEPTH * RATIO,
  localparam int WIDE_W       = NARROW_W * RATIO,
  localparam int NAW          = $clog2(NARROW_DEPTH),
  localparam int WAW          = $clog2(WIDE_DEPTH),
  localparam int LW           = $clog2(RATIO)
) (
  input  logic                n_clk,
  input  logic                n_rst_n,
  input  logic                n_en,
  input  logic                n_we,
  input  logic [NAW-1:0]      n_addr,
  input  logic [NARROW_W-1:0] n_wdata,
  output logic [NARROW_W-1:0] n_rdata,
  input  logic                w_clk,
  input  logic                w_rst_n,
  input  logic                w_en,
  input  logic                w_we,
  input  logic [WAW-1:0]      w_addr,
  input  logic [WIDE_W-1:0]   w_wdata,
  output logic [WIDE_W-1:0]   w_rdata
);
  import asym_dpram_pkg::*;

  port_op_e n_op;
  port_op_e w_op;
  logic n_rst_s;
  logic w_rst_s;
  logic [LW-1:0]       n_lane;
  logic [WAW-1:0]      n_row;
  logic [RATIO-1:0]    n_lane_we;
  logic                w_wr;
  logic [NARROW_W-1:0] n_lane_word [RATIO];
  logic [NARROW_W-1:0] w_lane_word [RATIO];
  logic [NARROW_W-1:0] n_sel_word;
  logic [WIDE_W-1:0]   w_sel_word;

  asym_rst_sync u_n_rst (.clk(n_clk), .rst_n_in(n_rst_n), .rst_n_out(n_rst_s));
  asym_rst_sync u_w_rst (.clk(w_clk), .rst_n_in(w_rst_n), .rst_n_out(w_rst_s));

  assign n_op   = port_op(n_en, n_we);
  assign w_op   = port_op(w_en, w_we);
  assign n_lane = n_addr[LW-1:0];
  assign n_row  = n_addr[NAW-1:LW];
  assign w_wr   = (w_op == OP_WRITE);

  for (genvar j = 0; j < RATIO; j++) begin : g_lane
    assign n_lane_we[j] = (n_op == OP_WRITE) && (n_lane == LW'(j));

    asym_lane_store #(.W(NARROW_W), .DEPTH(WIDE_DEPTH)) u_store (
      .a_clk  (n_clk),
      .a_we   (n_lane_we[j]),
      .a_row  (n_row),
      .a_wdata(n_wdata),
      .a_word (n_lane_word[j]),
      .b_clk  (w_clk),
      .b_we   (w_wr),
      .b_row  (w_addr),
      .b_wdata(w_wdata[j*NARROW_W +: NARROW_W]),
      .b_word (w_lane_word[j])
    );

    assign w_sel_word[j*NARROW_W +: NARROW_W] = w_lane_word[j];
  end

  assign n_sel_word = n_lane_word[n_lane];

  asym_read_reg #(.W(NARROW_W)) u_n_rd (
    .clk(n_clk), .rst_n(n_rst_s), .en(n_op != OP_IDLE),
    .d(n_sel_word), .q(n_rdata)
  );

  asym_read_reg #(.W(WIDE_W)) u_w_rd (
    .clk(w_clk), .rst_n(w_rst_s), .en(w_op != OP_IDLE),
    .d(w_sel_word), .q(w_rdata)
  );

  AST_NARROW_ONE_LANE: assert property (@(posedge n_clk) disable iff (!n_rst_s)
    $onehot0(n_lane_we)); // R3

  AST_NARROW_READ_FIRST: assert property (@(posedge n_clk) disable iff (!n_rst_s)
    (n_op == OP_WRITE) |=> (n_rdata == $past(n_sel_word))); // R6

  AST_WIDE_READ_LATENCY: assert property (@(posedge w_clk) disable iff (!w_rst_s)
    (w_op == OP_READ) |=> (w_rdata == $past(w_sel_word))); // R5
endmodule

// File: tb/asym_dpram_test.sv
`timescale 1ns/100ps
module asym_dpram_test;
  logic        n_clk = 1'b0;
  logic        w_clk = 1'b0;
  logic        n_rst_n, n_en, n_we;
  logic [9:0]  n_addr;
  logic [12:0] n_wdata, n_rdata;
  logic        w_rst_n, w_en, w_we;
  logic [8:0]  w_addr;
  logic [25:0] w_wdata, w_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [25:0] mdl [512];

  always #4   n_clk = ~n_clk;
  always #5.5 w_clk = ~w_clk;

  asym_dpram uut (
    .n_clk(n_clk), .n_rst_n(n_rst_n), .n_en(n_en), .n_we(n_we),
    .n_addr(n_addr), .n_wdata(n_wdata), .n_rdata(n_rdata),
    .w_clk(w_clk), .w_rst_n(w_rst_n), .w_en(w_en), .w_we(w_we),
    .w_addr(w_addr), .w_wdata(w_wdata), .w_rdata(w_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [25:0] act, input logic [25:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [25:0] wpat(input int k, input int s);
    return 26'((k * 40503) ^ (s * 1234567) ^ 26'h2AA_AAAA);
  endfunction

  function automatic logic [12:0] npat(input int a, input int s);
    return 13'((a * 2731) ^ (s * 977) ^ 13'h0F0F);
  endfunction

  function automatic logic [12:0] mdl_slice(input int a);
    logic [25:0] wd = mdl[a >> 1];
    return (a % 2 == 1) ? wd[25:13] : wd[12:0];
  endfunction

  task automatic n_op(input logic en, input logic we, input int a, input logic [12:0] d);
    @(negedge n_clk);
    n_en = en; n_we = we; n_addr = 10'(a); n_wdata = d;
    @(negedge n_clk);
    n_en = 1'b0; n_we = 1'b0;
    if (en && we) begin
      if (a % 2 == 1) mdl[a >> 1][25:13] = d;
      else            mdl[a >> 1][12:0]  = d;
    end
  endtask

  task automatic w_op(input logic en, input logic we, input int k, input logic [25:0] d);
    @(negedge w_clk);
    w_en = en; w_we = we; w_addr = 9'(k); w_wdata = d;
    @(negedge w_clk);
    w_en = 1'b0; w_we = 1'b0;
    if (en && we) mdl[k] = d;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 26'd0, 26'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [12:0] nhold;
    logic [25:0] whold;
    n_rst_n = 1'b0; w_rst_n = 1'b0;
    n_en = 0; n_we = 0; n_addr = '0; n_wdata = '0;
    w_en = 0; w_we = 0; w_addr = '0; w_wdata = '0;
    repeat (4) @(negedge w_clk);
    // R8: read data is zero during reset
    check(n_rdata == 13'd0, "R8 narrow reset", 26'(n_rdata), 26'd0);
    check(w_rdata == 26'd0, "R8 wide reset", w_rdata, 26'd0);
    @(negedge n_clk); n_rst_n = 1'b1;
    @(negedge w_clk); w_rst_n = 1'b1;
    repeat (4) @(negedge w_clk);

    // R4, R2, R1: wide fill, narrow read of every address
    for (int k = 0; k < 512; k++) w_op(1, 1, k, wpat(k, 1));
    for (int a = 0; a < 1024; a++) begin
      n_op(1, 0, a, '0);
      check(n_rdata == mdl_slice(a), "R2 narrow view of wide word", 26'(n_rdata), 26'(mdl_slice(a)));
    end

    // R2, R5: narrow fill, wide read of every word
    for (int a = 0; a < 1024; a++) n_op(1, 1, a, npat(a, 2));
    for (int k = 0; k < 512; k++) begin
      w_op(1, 0, k, '0);
      check(w_rdata == {npat(2*k+1, 2), npat(2*k, 2)}, "R5 wide view of narrow pair",
            w_rdata, {npat(2*k+1, 2), npat(2*k, 2)});
    end

    // R3: odd-only narrow rewrite keeps even slices
    for (int k = 0; k < 512; k++) n_op(1, 1, 2*k+1, npat(k, 3));
    for (int k = 0; k < 512; k++) begin
      w_op(1, 0, k, '0);
      check(w_rdata == {npat(k, 3), npat(2*k, 2)}, "R3 other slice untouched",
            w_rdata, {npat(k, 3), npat(2*k, 2)});
    end

    // R4: wide write replaces both slices
    w_op(1, 1, 77, 26'h3FF_C00F);
    n_op(1, 0, 154, '0);
    check(n_rdata == 13'h000F, "R4 wide low slice", 26'(n_rdata), 26'h000F);
    n_op(1, 0, 155, '0);
    check(n_rdata == 13'h1FFE, "R4 wide high slice", 26'(n_rdata), 26'h1FFE);

    // R6: read-first on both ports
    n_op(1, 1, 300, 13'h1234);
    check(n_rdata == npat(300, 2), "R6 narrow read-first", 26'(n_rdata), 26'(npat(300, 2)));
    n_op(1, 0, 300, '0);
    check(n_rdata == 13'h1234, "R6 narrow new value", 26'(n_rdata), 26'h1234);
    whold = mdl[40];
    w_op(1, 1, 40, 26'h155_AA55);
    check(w_rdata == whold, "R6 wide read-first", w_rdata, whold);
    w_op(1, 0, 40, '0);
    check(w_rdata == 26'h155_AA55, "R6 wide new value", w_rdata, 26'h155_AA55);

    // R7: enable low ignores write and holds read data
    nhold = n_rdata;
    n_op(0, 1, 300, 13'h0BAD);
    check(n_rdata == nhold, "R7 narrow hold", 26'(n_rdata), 26'(nhold));
    n_op(1, 0, 300, '0);
    check(n_rdata == 13'h1234, "R7 narrow no write", 26'(n_rdata), 26'h1234);
    whold = w_rdata;
    w_op(0, 1, 40, 26'h0DE_AD00);
    check(w_rdata == whold, "R7 wide hold", w_rdata, whold);
    w_op(1, 0, 40, '0);
    check(w_rdata == 26'h155_AA55, "R7 wide no write", w_rdata, 26'h155_AA55);

    // R8: narrow reset mid-run clears only narrow read data
    whold = w_rdata;
    @(negedge n_clk); n_rst_n = 1'b0;
    #1;
    check(n_rdata == 13'd0, "R8 narrow async clear", 26'(n_rdata), 26'd0);
    check(w_rdata == whold, "R8 wide unaffected", w_rdata, whold);
    @(negedge n_clk); n_rst_n = 1'b1;
    repeat (3) @(negedge n_clk);
    n_op(1, 0, 300, '0);
    check(n_rdata == 13'h1234, "R8 storage kept", 26'(n_rdata), 26'h1234);

    // R9: both clocks busy on disjoint rows
    fork
      begin
        for (int a = 0; a < 64; a++) n_op(1, 1, a, npat(a, 4));
      end
      begin
        for (int k = 256; k < 288; k++) begin
          w_op(1, 0, k, '0);
          check(w_rdata == mdl[k], "R9 concurrent wide read", w_rdata, mdl[k]);
        end
      end
    join
    for (int k = 0; k < 32; k++) begin
      w_op(1, 0, k, '0);
      check(w_rdata == {npat(2*k+1, 4), npat(2*k, 4)}, "R9 cross-domain data",
            w_rdata, {npat(2*k+1, 4), npat(2*k, 4)});
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule